// File: doc/BRIEF.md
# Receive Polarity Reversal Detector

This block sits behind a twisted-pair receiver and decides whether the receive pair is wired backwards. The receiver front end reports two kinds of events: a link-pulse strobe with the polarity that pulse arrived in, and an end-of-packet strobe with the polarity seen across that packet. The block keeps a separate run count of back-to-back reversed events for each kind. When either run reaches its limit, the wiring is considered reversed.

Once a reversal is confirmed, a status flag is raised and held. From the same cycle on, the receive data path is inverted, so the decoder downstream sees correctly polarized data and nobody has to fix the cable. The flag can drive a status indicator. Only a synchronous reset drops the flag and restores the straight data path.

Top module: `rx_polarity_guard`

## Requirements
- R1: During and right after a synchronous reset (`rst` high, active high), `rev_flag` is 0 and `rx_out` equals `rx_in`.
- R2: With the default limit of 7, `rev_flag` rises on the clock edge that samples the seventh consecutive link-pulse strobe carrying `lp_rev`=1. Before that edge it stays low.
- R3: With the default limit of 3, `rev_flag` rises on the clock edge that samples the third consecutive packet strobe carrying `pkt_rev`=1.
- R4: A strobe with correct polarity (`lp_rev`=0 or `pkt_rev`=0) restarts the reversed run for its own event kind. The next reversed run then needs the full count again.
- R5: The two runs are independent. A correct link pulse does not restart the packet run, and a correct packet does not restart the link-pulse run. Either run reaching its limit sets the flag.
- R6: Once set, `rev_flag` stays 1 whatever strobes arrive afterwards, correct or reversed.
- R7: `rx_out` equals `rx_in` with every bit inverted while `rev_flag` is 1, and equals `rx_in` while it is 0. With the default `OUT_REG`=0 the path is combinational.
- R8: A synchronous reset clears a set flag and both runs. After reset, a full run is needed again to set the flag.
- R9: Clock cycles with no strobe neither advance nor restart a run. Reversed events need not arrive in adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lp_stb | input | 1 | One-cycle strobe: a link pulse was seen |
| lp_rev | input | 1 | Polarity of that link pulse, 1 = reversed |
| pkt_stb | input | 1 | One-cycle strobe: a packet ended |
| pkt_rev | input | 1 | Polarity of that packet, 1 = reversed |
| rx_in | input | DATA_W | Raw receive data from the front end |
| rev_flag | output | 1 | Latched reversal status |
| rx_out | output | DATA_W | Receive data with polarity corrected |

## Verification
The embedded properties assume that each strobe is a single-cycle pulse and that its polarity input is valid in the same cycle. They also assume `rst` is applied at start-up before any strobe is checked. The bench drives every strobe for exactly one clock from the falling edge, so its polarity bit is settled at the sampling edge. It asserts reset for several cycles before any event. Link-pulse and packet strobes are sometimes driven in the same cycle and sometimes spread out with idle gaps. This covers both the independence of the runs and the rule that idle cycles do not count.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;

   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_GOOD = 2'd1,
      EV_REV  = 2'd2
   } ev_kind_e;

   function automatic ev_kind_e classify(input logic strobe, input logic reversed);
      if (!strobe)
         return EV_NONE;
      else if (reversed)
         return EV_REV;
      else
         return EV_GOOD;
   endfunction

endpackage

// File: rtl/rxpol_run_count.sv
module rxpol_run_count
   import rxpol_pkg::*;
#(
   parameter int LIMIT = 7
) (
   input  logic clk,
   input  logic rst,
   input  logic strobe,
   input  logic reversed,
   output logic hit
);
   localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("rxpol_run_count: LIMIT must be at least 2");
      end
   endgenerate

   ev_kind_e        kind;
   logic [CW-1:0]   run_q;

   always_comb begin
      kind = classify(strobe, reversed);
      hit  = (kind == EV_REV) && (run_q == LAST);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= '0;
      end else begin
         unique case (kind)
            EV_GOOD: run_q <= '0;
            EV_REV:  run_q <= hit ? '0 : run_q + 1'b1;
            default: run_q <= run_q;
         endcase
      end
   end

   // R4: a correctly polarized event restarts the run
   p_good_restarts_r4: assert property (@(posedge clk) disable iff (rst)
      (strobe && !reversed) |=> (run_q == '0));

   // R9: cycles without a strobe leave the run unchanged
   p_idle_holds_r9: assert property (@(posedge clk) disable iff (rst)
      !strobe |=> $stable(run_q));

   // R2: the run never exceeds the last index
   p_run_in_range_r2: assert property (@(posedge clk) disable iff (rst)
      run_q <= LAST);

endmodule

// File: rtl/rxpol_flag.sv
module rxpol_flag #(
   parameter int N_SRC = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_SRC-1:0] set_req,
   output logic             flag
);
   generate
      if (N_SRC < 1) begin : g_bad_src
         $error("rxpol_flag: N_SRC must be at least 1");
      end
   endgenerate

   logic any_set;
   logic flag_q;

   always_comb any_set = |set_req;

   always_ff @(posedge clk) begin
      if (rst)
         flag_q <= 1'b0;
      else if (any_set)
         flag_q <= 1'b1;
   end

   assign flag = flag_q;

   // R6: the flag holds until reset
   p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      flag_q |=> flag_q);

   // R5: a request from either source sets the flag
   p_any_source_sets_r5: assert property (@(posedge clk) disable iff (rst)
      (set_req != '0) |=> flag_q);

   // R8: reset clears the flag
   p_reset_clears_r8: assert property (@(posedge clk)
      rst |=> !flag_q);

endmodule

// File: rtl/rxpol_fix.sv
module rxpol_fix #(
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              invert,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("rxpol_fix: DATA_W must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0] mask;
   always_comb mask = {DATA_W{invert}};

   generate
      if (OUT_REG) begin : g_reg
         logic [DATA_W-1:0] dout_q;
         always_ff @(posedge clk) begin
            if (rst)
               dout_q <= '0;
            else
               dout_q <= din ^ mask;
         end
         assign dout = dout_q;
      end else begin : g_comb
         assign dout = din ^ mask;
      end
   endgenerate

endmodule

// File: rtl/rx_polarity_guard.sv
module rx_polarity_guard
   import rxpol_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int LP_LIMIT  = 7,
   parameter int PKT_LIMIT = 3,
   parameter bit OUT_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              lp_stb,
   input  logic              lp_rev,
   input  logic              pkt_stb,
   input  logic              pkt_rev,
   input  logic [DATA_W-1:0] rx_in,
   output logic              rev_flag,
   output logic [DATA_W-1:0] rx_out
);
   localparam int N_SRC = 2;

   logic [N_SRC-1:0] src_stb;
   logic [N_SRC-1:0] src_rev;
   logic [N_SRC-1:0] src_hit;

   always_comb begin
      src_stb = {pkt_stb, lp_stb};
      src_rev = {pkt_rev, lp_rev};
   end

   generate
      for (genvar g = 0; g < N_SRC; g++) begin : g_src
         localparam int LIM = (g == 0) ? LP_LIMIT : PKT_LIMIT;
         rxpol_run_count #(.LIMIT(LIM)) u_run (
            .clk      (clk),
            .rst      (rst),
            .strobe   (src_stb[g]),
            .reversed (src_rev[g]),
            .hit      (src_hit[g])
         );
      end
   endgenerate

   rxpol_flag #(.N_SRC(N_SRC)) u_flag (
      .clk     (clk),
      .rst     (rst),
      .set_req (src_hit),
      .flag    (rev_flag)
   );

   rxpol_fix #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_fix (
      .clk    (clk),
      .rst    (rst),
      .invert (rev_flag),
      .din    (rx_in),
      .dout   (rx_out)
   );

   // R2: the flag only rises when a reversed strobe was sampled
   p_rise_needs_event_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(rev_flag) |-> $past((lp_stb && lp_rev) || (pkt_stb && pkt_rev)));

   generate
      if (!OUT_REG) begin : g_chk_comb
         // R7: the data path follows the flag
         p_data_follows_r7: assert property (@(posedge clk) disable iff (rst)
            (rx_out == (rev_flag ? ~rx_in : rx_in)));
      end
   endgenerate

endmodule

// File: tb/test_rx_polarity_guard.sv
module test_rx_polarity_guard;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic lp_stb = 1'b0, lp_rev = 1'b0, pkt_stb = 1'b0, pkt_rev = 1'b0;
   logic [DW-1:0] rx_in = '0;
   logic rev_flag;
   logic [DW-1:0] rx_out;

   int checks = 0;
   int failures = 0;
   int m_lp = 0, m_pk = 0;
   bit m_flag = 0;
   bit done = 0;
   logic [7:0] lfsr = 8'h5a;

   always #5 clk = ~clk;

   rx_polarity_guard #(.DATA_W(DW)) i_rx_polarity_guard (
      .clk(clk), .rst(rst), .lp_stb(lp_stb), .lp_rev(lp_rev),
      .pkt_stb(pkt_stb), .pkt_rev(pkt_rev), .rx_in(rx_in),
      .rev_flag(rev_flag), .rx_out(rx_out)
   );

   // changing receive data
   always @(negedge clk) begin
      lfsr  <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rx_in <= lfsr;
   end

   // behavioural reference, compared every cycle
   always @(posedge clk) begin
      if (rst) begin
         m_lp = 0; m_pk = 0; m_flag = 0;
      end else begin
         if (lp_stb) begin
            if (lp_rev) begin
               m_lp++;
               if (m_lp == 7) begin m_flag = 1; m_lp = 0; end
            end else m_lp = 0;
         end
         if (pkt_stb) begin
            if (pkt_rev) begin
               m_pk++;
               if (m_pk == 3) begin m_flag = 1; m_pk = 0; end
            end else m_pk = 0;
         end
      end
      #2;
      checks++;
      if (rev_flag !== m_flag) begin
         failures++;
         $display("FAIL R6 model flag: actual=%0b expected=%0b t=%0t", rev_flag, m_flag, $time);
      end
      checks++;
      if (rx_out !== (m_flag ? ~rx_in : rx_in)) begin
         failures++;
         $display("FAIL R7 model data: actual=%h expected=%h t=%0t", rx_out,
                  m_flag ? ~rx_in : rx_in, $time);
      end
   end

   task automatic chk(input string tag, input bit exp);
      checks++;
      if (rev_flag !== exp) begin
         failures++;
         $display("FAIL %s flag: actual=%0b expected=%0b", tag, rev_flag, exp);
      end
   endtask

   task automatic ev(input bit l, input bit lr, input bit p, input bit pr);
      @(negedge clk);
      lp_stb = l; lp_rev = lr; pkt_stb = p; pkt_rev = pr;
      @(negedge clk);
      lp_stb = 0; lp_rev = 0; pkt_stb = 0; pkt_rev = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1;
      idle(3);
      chk("R1", 0);
      checks++;
      if (rx_out !== rx_in) begin
         failures++;
         $display("FAIL R1 data: actual=%h expected=%h", rx_out, rx_in);
      end
      rst = 0;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R2: seven reversed link pulses
      for (int i = 0; i < 6; i++) ev(1, 1, 0, 0);
      chk("R2 after six", 0);
      ev(1, 1, 0, 0);
      chk("R2 after seven", 1);
      // R6: further events keep the flag
      ev(1, 0, 1, 0);
      ev(1, 1, 1, 1);
      idle(4);
      chk("R6", 1);
      // R8: reset clears
      do_reset();
      chk("R8", 0);
      // R3: three reversed packets, with idle gaps (R9)
      ev(0, 0, 1, 1); idle(5);
      ev(0, 0, 1, 1); idle(9);
      chk("R9 gaps", 0);
      ev(0, 0, 1, 1);
      chk("R3", 1);
      do_reset();
      // R4: a good pulse restarts the link run
      for (int i = 0; i < 6; i++) ev(1, 1, 0, 0);
      ev(1, 0, 0, 0);
      for (int i = 0; i < 6; i++) ev(1, 1, 0, 0);
      chk("R4 link", 0);
      ev(1, 1, 0, 0);
      chk("R4 link full run", 1);
      do_reset();
      ev(0, 0, 1, 1); ev(0, 0, 1, 1); ev(0, 0, 1, 0);
      ev(0, 0, 1, 1); ev(0, 0, 1, 1);
      chk("R4 packet", 0);
      // R5: good link pulses do not restart packet run
      ev(1, 0, 0, 0);
      ev(1, 0, 1, 1);
      chk("R5 packet survives", 1);
      do_reset();
      // R5: good packets do not restart the link run; both strobes together
      for (int i = 0; i < 6; i++) ev(1, 1, 1, 0);
      chk("R5 link before", 0);
      ev(1, 1, 1, 0);
      chk("R5 link survives", 1);
      idle(3);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule